// File: doc/BRIEF.md
# Interrupt Pin Dispatcher

The block holds one pending-request bit (IRR) per interrupt input pin and decides when each pin turns into a delivery request. Line activity arrives as per-pin strobes that carry the line's new level. Each pin's entry in an external redirection table supplies its mask, its trigger kind (edge or level), its remote-IRR flag, its vector and its destination. An edge pin asks for delivery once per fresh assertion. A level pin asks while it is asserted, but it is blocked while its remote-IRR flag is set. That flag marks a level interrupt that a destination took and has not yet acknowledged.

End-of-interrupt (EOI) broadcasts carry a vector. Every level pin whose vector matches has its remote IRR cleared. It is delivered again if it is still asserted and unmasked. A per-pin counter catches a storm of back-to-back EOI re-deliveries. On the limit-th such re-delivery the block holds off for a programmable number of cycles, then sweeps every eligible level pin. Delivery requests leave one at a time through a valid/ready port. The receiver reports on the same handshake whether any destination accepted the interrupt. Destination matching is done outside the block.

Top module: `pin_dispatch`

## Requirements
- R1: A line strobe with level 0 clears the pin's IRR bit and reports a non-coalesced status. A later assertion of an edge pin is then treated as fresh and delivered.
- R2: A line strobe with level 1 on an edge pin whose IRR bit is already set reports coalesced (stat_coal_o bit = 1) and makes no delivery request.
- R3: No request is issued for a pin while its mask bit is 1. No request is issued for a level pin (level_trig_i bit = 1) while its remote-IRR input is 1.
- R4: At a handshake (req_valid_o and req_ready_i both 1) of a level pin with req_taken_i = 1, rirr_set_o pulses with only that pin's bit set. For an edge pin, or with req_taken_i = 0, rirr_set_o stays 0.
- R5: In a cycle with eoi_valid_i = 1, every level pin whose vector equals eoi_vector_i gets a rirr_clr_o pulse in that same cycle. A matching pin that is unmasked with IRR set is requested again.
- R6: An EOI that matches a level pin which is masked or has its IRR clear makes no request and resets that pin's storm counter to zero.
- R7: The STORM_LIMIT-th consecutive EOI re-delivery of a pin is not issued at once. The counter returns to zero, and after DEFER_CYCLES cycles every level pin with IRR set and remote IRR clear is requested.
- R8: A cfg_wr_i pulse naming a level pin whose IRR bit is set causes a delivery attempt. A cfg_wr_i pulse naming an edge pin pulses that pin's rirr_clr_o bit in the same cycle.
- R9: Requests leave one per handshake, with the lowest-numbered pending pin first. While req_valid_o = 1 and req_ready_i = 0, pin, vector and destination hold steady.
- R10: stat_stb_o repeats line_stb_i one cycle later, and stat_coal_o is only set on bits where stat_stb_o is set.
- R11: After reset, req_valid_o, rirr_set_o and stat_stb_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_stb_i | input | NUM_PINS | Per-pin line event strobe |
| line_lvl_i | input | NUM_PINS | New line level for strobed pins |
| mask_i | input | NUM_PINS | Table mask bits |
| level_trig_i | input | NUM_PINS | Table trigger kind, 1 = level |
| rirr_i | input | NUM_PINS | Table remote-IRR bits |
| vector_i | input | NUM_PINS*VEC_W | Table vectors, pin p at bits p*VEC_W |
| dest_i | input | NUM_PINS*DEST_W | Table destinations, pin p at bits p*DEST_W |
| cfg_wr_i | input | 1 | Table entry rewritten |
| cfg_pin_i | input | PIN_W | Rewritten entry index |
| eoi_valid_i | input | 1 | EOI broadcast strobe |
| eoi_vector_i | input | VEC_W | EOI vector |
| req_valid_o | output | 1 | Delivery request valid |
| req_ready_i | input | 1 | Delivery request ready |
| req_taken_i | input | 1 | At least one destination accepted, sampled at handshake |
| req_pin_o | output | PIN_W | Requesting pin |
| req_vector_o | output | VEC_W | Request vector |
| req_dest_o | output | DEST_W | Request destination |
| req_level_o | output | 1 | Request is level-triggered |
| rirr_set_o | output | NUM_PINS | Remote-IRR set strobes |
| rirr_clr_o | output | NUM_PINS | Remote-IRR clear strobes |
| stat_stb_o | output | NUM_PINS | Status valid per line strobe |
| stat_coal_o | output | NUM_PINS | Status: assertion coalesced |

## Verification
Arbitration and the output handshake can fall in the same cycle. The bench asserts two edge pins in one strobe cycle while the receiver is stalled. It then releases ready, so the higher pin is loaded in the very cycle the lower one is accepted. The scoreboard judges this by strict order and by the absence of any duplicate. A level pin's remote-IRR set strobe and an EOI's re-delivery also interleave through the external table model. The check there is that every re-delivery arrives only after the clear, and that a deferred one stays silent for the whole hold-off window.

// File: rtl/pdisp_pkg.sv
package pdisp_pkg;
  localparam int unsigned PINS_DEF  = 8;
  localparam int unsigned VEC_DEF   = 8;
  localparam int unsigned DEST_DEF  = 8;
  localparam int unsigned STORM_DEF = 10000;
  localparam int unsigned DEFER_DEF = 1000;

  function automatic int unsigned cw(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/pdisp_irr.sv
module pdisp_irr #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] line_stb_i,
  input  logic [NUM_PINS-1:0] line_lvl_i,
  input  logic [NUM_PINS-1:0] level_trig_i,
  input  logic [NUM_PINS-1:0] pend_add_i,
  input  logic [NUM_PINS-1:0] pend_take_i,
  output logic [NUM_PINS-1:0] irr_o,
  output logic [NUM_PINS-1:0] pend_o,
  output logic [NUM_PINS-1:0] stat_stb_o,
  output logic [NUM_PINS-1:0] stat_coal_o
);
  logic [NUM_PINS-1:0] irr_q, irr_d, pend_q, pend_d, coal_d;

  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      logic up, dn, fresh;
      up        = line_stb_i[p] & line_lvl_i[p];
      dn        = line_stb_i[p] & ~line_lvl_i[p];
      coal_d[p] = up & ~level_trig_i[p] & irr_q[p];
      fresh     = up & ~coal_d[p];
      irr_d[p]  = dn ? 1'b0 : (up ? 1'b1 : irr_q[p]);
      // a new request wins over a take in the same cycle
      pend_d[p] = (pend_q[p] & ~pend_take_i[p]) | pend_add_i[p] | fresh;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q       <= '0;
      pend_q      <= '0;
      stat_stb_o  <= '0;
      stat_coal_o <= '0;
    end else begin
      irr_q       <= irr_d;
      pend_q      <= pend_d;
      stat_stb_o  <= line_stb_i;
      stat_coal_o <= coal_d;
    end
  end

  assign irr_o  = irr_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/pdisp_storm.sv
module pdisp_storm
  import pdisp_pkg::*;
#(
  parameter int unsigned NUM_PINS     = 8,
  parameter int unsigned STORM_LIMIT  = 10000,
  parameter int unsigned DEFER_CYCLES = 1000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] eoi_hit_i,
  input  logic [NUM_PINS-1:0] mask_i,
  input  logic [NUM_PINS-1:0] irr_i,
  output logic [NUM_PINS-1:0] redo_o,
  output logic                sweep_o
);
  localparam int unsigned CW = cw(STORM_LIMIT);
  localparam int unsigned TW = cw(DEFER_CYCLES);
  localparam logic [CW-1:0] CNT_LAST = CW'(STORM_LIMIT - 1);
  localparam logic [TW-1:0] TMR_LAST = TW'(DEFER_CYCLES - 1);

  logic [NUM_PINS-1:0] defer_req;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [CW-1:0] cnt_q;
    logic          live;
    assign live         = eoi_hit_i[p] & ~mask_i[p] & irr_i[p];
    assign defer_req[p] = live & (cnt_q == CNT_LAST);
    assign redo_o[p]    = live & ~defer_req[p];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      cnt_q <= '0;
      else if (eoi_hit_i[p]) begin
        if (redo_o[p])                  cnt_q <= cnt_q + 1'b1;
        else                            cnt_q <= '0;
      end
    end
  end

  logic          run_q;
  logic [TW-1:0] tmr_q;
  assign sweep_o = run_q & (tmr_q == TMR_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      tmr_q <= '0;
    end else if (run_q) begin
      if (sweep_o) run_q <= 1'b0;
      tmr_q <= tmr_q + 1'b1;
    end else if (|defer_req) begin
      run_q <= 1'b1;
      tmr_q <= '0;
    end
  end
endmodule

// File: rtl/pdisp_arb.sv
module pdisp_arb
  import pdisp_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned DEST_W   = 8,
  localparam int unsigned PIN_W   = cw(NUM_PINS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_PINS-1:0]        pend_i,
  input  logic [NUM_PINS-1:0]        irr_i,
  input  logic [NUM_PINS-1:0]        mask_i,
  input  logic [NUM_PINS-1:0]        level_trig_i,
  input  logic [NUM_PINS-1:0]        rirr_i,
  input  logic [NUM_PINS*VEC_W-1:0]  vector_i,
  input  logic [NUM_PINS*DEST_W-1:0] dest_i,
  input  logic                       req_ready_i,
  output logic [NUM_PINS-1:0]        take_o,
  output logic                       req_valid_o,
  output logic [PIN_W-1:0]           req_pin_o,
  output logic [VEC_W-1:0]           req_vector_o,
  output logic [DEST_W-1:0]          req_dest_o,
  output logic                       req_level_o
);
  logic [NUM_PINS-1:0] elig, cand;
  logic                found, load;
  logic [PIN_W-1:0]    sel;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      elig[p] = ~mask_i[p] & (~level_trig_i[p] | (irr_i[p] & ~rirr_i[p]));
      // a level pin sitting in the output stage waits for its remote IRR
      cand[p] = pend_i[p] & elig[p] &
                ~(req_valid_o & req_level_o & (req_pin_o == PIN_W'(p)));
      if (!found && cand[p]) begin
        found = 1'b1;
        sel   = PIN_W'(p);
      end
    end
    load = found & (~req_valid_o | req_ready_i);
    for (int p = 0; p < NUM_PINS; p++)
      take_o[p] = (pend_i[p] & ~elig[p]) | (load & (sel == PIN_W'(p)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_valid_o  <= 1'b0;
      req_pin_o    <= '0;
      req_vector_o <= '0;
      req_dest_o   <= '0;
      req_level_o  <= 1'b0;
    end else if (load) begin
      req_valid_o  <= 1'b1;
      req_pin_o    <= sel;
      req_vector_o <= vector_i[int'(sel)*VEC_W +: VEC_W];
      req_dest_o   <= dest_i[int'(sel)*DEST_W +: DEST_W];
      req_level_o  <= level_trig_i[sel];
    end else if (req_ready_i) begin
      req_valid_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/pin_dispatch.sv
module pin_dispatch
  import pdisp_pkg::*;
#(
  parameter int unsigned NUM_PINS     = PINS_DEF,
  parameter int unsigned VEC_W        = VEC_DEF,
  parameter int unsigned DEST_W       = DEST_DEF,
  parameter int unsigned STORM_LIMIT  = STORM_DEF,
  parameter int unsigned DEFER_CYCLES = DEFER_DEF,
  localparam int unsigned PIN_W       = cw(NUM_PINS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_PINS-1:0]        line_stb_i,
  input  logic [NUM_PINS-1:0]        line_lvl_i,
  input  logic [NUM_PINS-1:0]        mask_i,
  input  logic [NUM_PINS-1:0]        level_trig_i,
  input  logic [NUM_PINS-1:0]        rirr_i,
  input  logic [NUM_PINS*VEC_W-1:0]  vector_i,
  input  logic [NUM_PINS*DEST_W-1:0] dest_i,
  input  logic                       cfg_wr_i,
  input  logic [PIN_W-1:0]           cfg_pin_i,
  input  logic                       eoi_valid_i,
  input  logic [VEC_W-1:0]           eoi_vector_i,
  output logic                       req_valid_o,
  input  logic                       req_ready_i,
  input  logic                       req_taken_i,
  output logic [PIN_W-1:0]           req_pin_o,
  output logic [VEC_W-1:0]           req_vector_o,
  output logic [DEST_W-1:0]          req_dest_o,
  output logic                       req_level_o,
  output logic [NUM_PINS-1:0]        rirr_set_o,
  output logic [NUM_PINS-1:0]        rirr_clr_o,
  output logic [NUM_PINS-1:0]        stat_stb_o,
  output logic [NUM_PINS-1:0]        stat_coal_o
);
  logic [NUM_PINS-1:0] irr, pend, take, redo, eoi_hit, cfg_req, sweep_set, pend_add;
  logic                sweep, fire;

  assign fire = req_valid_o & req_ready_i;

  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      logic sel_cfg;
      sel_cfg       = cfg_wr_i & (cfg_pin_i == PIN_W'(p));
      eoi_hit[p]    = eoi_valid_i & level_trig_i[p] &
                      (vector_i[p*VEC_W +: VEC_W] == eoi_vector_i);
      cfg_req[p]    = sel_cfg & level_trig_i[p] & irr[p];
      sweep_set[p]  = sweep & level_trig_i[p] & irr[p] & ~rirr_i[p];
      rirr_clr_o[p] = eoi_hit[p] | (sel_cfg & ~level_trig_i[p]);
      rirr_set_o[p] = fire & req_level_o & req_taken_i & (req_pin_o == PIN_W'(p));
    end
  end

  assign pend_add = redo | cfg_req | sweep_set;

  pdisp_irr #(.NUM_PINS(NUM_PINS)) i_irr (
    .clk_i, .rst_ni,
    .line_stb_i, .line_lvl_i, .level_trig_i,
    .pend_add_i  (pend_add),
    .pend_take_i (take),
    .irr_o       (irr),
    .pend_o      (pend),
    .stat_stb_o, .stat_coal_o
  );

  pdisp_storm #(
    .NUM_PINS(NUM_PINS), .STORM_LIMIT(STORM_LIMIT), .DEFER_CYCLES(DEFER_CYCLES)
  ) i_storm (
    .clk_i, .rst_ni,
    .eoi_hit_i (eoi_hit),
    .mask_i,
    .irr_i     (irr),
    .redo_o    (redo),
    .sweep_o   (sweep)
  );

  pdisp_arb #(.NUM_PINS(NUM_PINS), .VEC_W(VEC_W), .DEST_W(DEST_W)) i_arb (
    .clk_i, .rst_ni,
    .pend_i (pend),
    .irr_i  (irr),
    .mask_i, .level_trig_i, .rirr_i, .vector_i, .dest_i, .req_ready_i,
    .take_o (take),
    .req_valid_o, .req_pin_o, .req_vector_o, .req_dest_o, .req_level_o
  );
endmodule

// File: rtl/pdisp_chk.sv
module pdisp_chk #(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned DEST_W   = 8,
  parameter int unsigned PIN_W    = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_PINS-1:0] line_stb_i,
  input logic [NUM_PINS-1:0] mask_i,
  input logic [NUM_PINS-1:0] level_trig_i,
  input logic [NUM_PINS-1:0] rirr_i,
  input logic                req_valid_o,
  input logic                req_ready_i,
  input logic [PIN_W-1:0]    req_pin_o,
  input logic [VEC_W-1:0]    req_vector_o,
  input logic [DEST_W-1:0]   req_dest_o,
  input logic [NUM_PINS-1:0] rirr_set_o,
  input logic [NUM_PINS-1:0] stat_stb_o,
  input logic [NUM_PINS-1:0] stat_coal_o
);
  logic                vld_d, fire_d;
  logic [NUM_PINS-1:0] mask_d, lvl_d, rirr_d, stb_d;
  logic                new_item;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_d  <= 1'b0;
      fire_d <= 1'b0;
      mask_d <= '0;
      lvl_d  <= '0;
      rirr_d <= '0;
      stb_d  <= '0;
    end else begin
      vld_d  <= req_valid_o;
      fire_d <= req_valid_o & req_ready_i;
      mask_d <= mask_i;
      lvl_d  <= level_trig_i;
      rirr_d <= rirr_i;
      stb_d  <= line_stb_i;
    end
  end

  assign new_item = req_valid_o & (~vld_d | fire_d);

  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_pin_o) &&
    $stable(req_vector_o) && $stable(req_dest_o));

  // R3
  masked_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_item |-> !mask_d[req_pin_o]);

  // R3
  rirr_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_item && lvl_d[req_pin_o] |-> !rirr_d[req_pin_o]);

  // R4
  rirr_set_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rirr_set_o) && ((rirr_set_o == '0) || (req_valid_o && req_ready_i)));

  // R10
  stat_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_stb_o == stb_d) && ((stat_coal_o & ~stat_stb_o) == '0));
endmodule

bind pin_dispatch pdisp_chk #(
  .NUM_PINS(NUM_PINS), .VEC_W(VEC_W), .DEST_W(DEST_W), .PIN_W(PIN_W)
) i_pdisp_chk (.*);

// File: tb/test_pin_dispatch.sv
module test_pin_dispatch;
  import pdisp_pkg::*;
  localparam int unsigned CLK_P = 10;
  localparam int unsigned N     = 8;
  localparam int unsigned VW    = 8;
  localparam int unsigned DW    = 8;
  localparam int unsigned LIMIT = 4;
  localparam int unsigned DEFER = 20;
  localparam int unsigned PW    = cw(N);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] line_stb = '0, line_lvl = '0, mask = '0, lvl_cfg = '0, rirr = '0;
  logic [N*VW-1:0] vec_cfg;
  logic [N*DW-1:0] dst_cfg;
  logic cfg_wr = 1'b0, eoi_valid = 1'b0, ready = 1'b1, taken = 1'b1;
  logic [PW-1:0] cfg_pin = '0;
  logic [VW-1:0] eoi_vec = '0;
  logic req_valid, req_level;
  logic [PW-1:0] req_pin;
  logic [VW-1:0] req_vector;
  logic [DW-1:0] req_dest;
  logic [N-1:0] rirr_set, rirr_clr, stat_stb, stat_coal;

  int checks = 0, errors = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pin_dispatch #(
    .NUM_PINS(N), .VEC_W(VW), .DEST_W(DW), .STORM_LIMIT(LIMIT), .DEFER_CYCLES(DEFER)
  ) i_pin_dispatch (
    .clk_i(clk), .rst_ni(rst_n),
    .line_stb_i(line_stb), .line_lvl_i(line_lvl), .mask_i(mask),
    .level_trig_i(lvl_cfg), .rirr_i(rirr), .vector_i(vec_cfg), .dest_i(dst_cfg),
    .cfg_wr_i(cfg_wr), .cfg_pin_i(cfg_pin),
    .eoi_valid_i(eoi_valid), .eoi_vector_i(eoi_vec),
    .req_valid_o(req_valid), .req_ready_i(ready), .req_taken_i(taken),
    .req_pin_o(req_pin), .req_vector_o(req_vector), .req_dest_o(req_dest),
    .req_level_o(req_level), .rirr_set_o(rirr_set), .rirr_clr_o(rirr_clr),
    .stat_stb_o(stat_stb), .stat_coal_o(stat_coal)
  );

  // redirection table remote-IRR model: set wins over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rirr <= '0;
    else        rirr <= (rirr & ~rirr_clr) | rirr_set;
  end

  function automatic void chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && req_valid && ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3", "unexpected request pin", req_pin, 0);
      end else begin
        int p;
        p = exp_q.pop_front();
        chk(req_pin == PW'(p), "R9", "request pin order", req_pin, p);
        chk(req_vector == VW'(8'h40 + p), "R9", "request vector", req_vector, 8'h40 + p);
        chk(req_dest == DW'(8'h10 + p), "R9", "request dest", req_dest, 8'h10 + p);
        chk(req_level == lvl_cfg[p], "R4", "request level", req_level, lvl_cfg[p]);
        chk(rirr_set == ((lvl_cfg[p] && taken) ? N'(1) << p : '0), "R4",
            "remote IRR set strobe", rirr_set, (lvl_cfg[p] && taken) ? (1 << p) : 0);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle(int n);
    repeat (n) step();
  endtask

  task automatic line_evt(int p, bit lvl, bit exp_coal, bit exp_req, string req);
    line_stb[p] = 1'b1;
    line_lvl[p] = lvl;
    if (exp_req) exp_q.push_back(p);
    step();
    line_stb = '0;
    line_lvl = '0;
    chk(stat_stb[p] == 1'b1, "R10", "status strobe", stat_stb[p], 1);
    chk(stat_coal[p] == exp_coal, req, "coalesced status", stat_coal[p], exp_coal);
  endtask

  task automatic eoi(logic [VW-1:0] v, logic [N-1:0] exp_clr, int exp_pin);
    eoi_valid = 1'b1;
    eoi_vec   = v;
    #1;
    chk(rirr_clr == exp_clr, "R5", "EOI clear strobes", rirr_clr, exp_clr);
    if (exp_pin >= 0) exp_q.push_back(exp_pin);
    step();
    eoi_valid = 1'b0;
  endtask

  task automatic drained(string req);
    chk(exp_q.size() == 0, req, "expected requests still outstanding", exp_q.size(), 0);
  endtask

  initial begin
    for (int p = 0; p < N; p++) begin
      vec_cfg[p*VW +: VW] = VW'(8'h40 + p);
      dst_cfg[p*DW +: DW] = DW'(8'h10 + p);
    end
    lvl_cfg = 8'b0110_0010;   // pins 1, 5, 6 level
    mask    = 8'b0001_0010;   // pins 1, 4 masked
    #(3*CLK_P) rst_n = 1'b1;
    step();
    // R11 reset state
    chk(req_valid == 1'b0, "R11", "req_valid after reset", req_valid, 0);
    chk(rirr_set == '0, "R11", "rirr_set after reset", rirr_set, 0);
    chk(stat_stb == '0, "R11", "stat_stb after reset", stat_stb, 0);

    // edge delivery, then coalescing, then deassert and fresh assert
    line_evt(2, 1'b1, 1'b0, 1'b1, "R2");
    idle(5);
    line_evt(2, 1'b1, 1'b1, 1'b0, "R2");
    idle(5);
    line_evt(2, 1'b0, 1'b0, 1'b0, "R1");
    line_evt(2, 1'b1, 1'b0, 1'b1, "R1");
    idle(5);
    drained("R1");

    // R3 masked edge pin
    line_evt(4, 1'b1, 1'b0, 1'b0, "R3");
    idle(6);
    // level pin taken -> remote IRR set; reassert while remote IRR held
    line_evt(6, 1'b1, 1'b0, 1'b1, "R4");
    idle(5);
    chk(rirr[6] == 1'b1, "R4", "table remote IRR pin 6", rirr[6], 1);
    line_evt(6, 1'b1, 1'b0, 1'b0, "R3");
    idle(6);
    drained("R3");

    // R5 EOI re-delivers asserted level pin
    eoi(8'h46, 8'h40, 6);
    idle(6);
    drained("R5");

    // R6 EOI with IRR clear: no delivery, counter reset
    line_evt(6, 1'b0, 1'b0, 1'b0, "R1");
    eoi(8'h46, 8'h40, -1);
    idle(5);
    line_evt(6, 1'b1, 1'b0, 1'b1, "R6");
    idle(5);
    for (int k = 0; k < LIMIT - 1; k++) begin
      eoi(8'h46, 8'h40, 6);
      idle(6);
    end
    drained("R6");

    // R7 limit-th re-delivery deferred, then swept
    eoi(8'h46, 8'h40, -1);
    idle(DEFER - 1);
    drained("R7");
    exp_q.push_back(6);
    idle(8);
    drained("R7");
    eoi(8'h46, 8'h40, 6);
    idle(6);
    drained("R7");

    // R8 rewrite of a level entry with IRR set
    line_evt(1, 1'b1, 1'b0, 1'b0, "R3");
    idle(4);
    mask[1] = 1'b0;
    cfg_wr  = 1'b1;
    cfg_pin = PW'(1);
    exp_q.push_back(1);
    step();
    cfg_wr = 1'b0;
    idle(6);
    drained("R8");
    cfg_wr  = 1'b1;
    cfg_pin = PW'(7);
    #1;
    chk(rirr_clr == 8'h80, "R8", "edge rewrite clears remote IRR", rirr_clr, 8'h80);
    step();
    cfg_wr = 1'b0;

    // R9 priority and hold under back-pressure
    ready = 1'b0;
    line_stb = 8'b0000_1001;
    line_lvl = 8'b0000_1001;
    exp_q.push_back(0);
    exp_q.push_back(3);
    step();
    line_stb = '0;
    line_lvl = '0;
    chk(stat_stb == 8'b0000_1001, "R10", "dual status strobe", stat_stb, 8'b0000_1001);
    idle(3);
    chk(req_valid && req_pin == 0, "R9", "lowest pin first", req_pin, 0);
    idle(3);
    chk(req_valid && req_pin == 0, "R9", "held under stall", req_pin, 0);
    ready = 1'b1;
    idle(6);
    drained("R9");

    // R4 level delivery not taken: no remote IRR set
    taken = 1'b0;
    line_evt(5, 1'b1, 1'b0, 1'b1, "R4");
    idle(6);
    chk(rirr[5] == 1'b0, "R4", "not taken leaves remote IRR", rirr[5], 0);
    taken = 1'b1;
    drained("R4");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule